// File: doc/BRIEF.md
# Ternary Lookup Table with Priority Index

This block is a small content-addressable table for address translation. Each of its `DEPTH` entries (32 by default) holds a 64-bit word plus a valid flag. A host stages a word through a 32-bit command port and then stores it. The word can be staged as two raw halves, or as a value/mask pair that the block turns into ternary digits. The host then writes the staged word at an explicit index, at the lowest free index, or over the lowest entry that a ternary key hits. Entries are removed by index or by an exact match on the staged word.

Each ternary digit n (0..31) lives in the bit pair (n, n+32). Stored 1 is (1,0), stored 0 is (0,1), and don't-care is (0,0). A ternary search takes one 32-bit key. The key is the comparand and mask for bits 31..0, and its complement is the comparand and mask for bits 63..32. A binary search compares all 64 bits of the staged word exactly. When several entries hit, the lowest index wins. Placing longer prefixes at lower indices therefore makes a ternary search return the longest matching prefix.

Commands arrive on a valid/ready channel. Searches and reads return one result on a valid/ready result channel, one cycle after the command is accepted, however full the table is. `cmd_ready` is low while a result is waiting and `res_ready` is low. A held result keeps all its fields unchanged until it is taken. Every store and every removal also pulses a plain index strobe so that an associated RAM can follow the table.

Top module: `tcam_lookup`

## Requirements
- R1: STAGE_TERN (op 2) with value A in `cmd_data` and mask M in `cmd_mask` stages A&M as bits 31..0 and ~A&M as bits 63..32. STAGE_LO (op 0) and STAGE_HI (op 1) stage the raw halves. RD_LO (op 10) and RD_HI (op 11) return bits 31..0 and 63..32 of the entry at `cmd_index` in `res_data`, with `res_match` equal to that entry's valid flag and `res_index` equal to `cmd_index`.
- R2: SRCH_TERN (op 8) with key K hits a valid entry when its low half has no 1 where K is 0 and its high half has no 1 where K is 1.
- R3: When several entries hit, `res_index` is the lowest hitting index.
- R4: SRCH_BIN (op 9) hits only valid entries whose 64 bits equal the staged word.
- R5: A search with no hit returns `res_match`=0 and `res_index`=0.
- R6: Every accepted search or read raises `res_valid` in the cycle after acceptance. Any other accepted op leaves `res_valid` low in that cycle. Op codes 12..15 change nothing.
- R7: While `res_valid` is high and `res_ready` is low, `cmd_ready` is low and the result fields stay stable.
- R8: WR_IDX (op 3) stores the staged word at `cmd_index` and sets its valid flag. In the next cycle `upd_strobe`=1, `upd_write`=1 and `upd_index` is that index.
- R9: DEL_IDX (op 6) clears the valid flag at `cmd_index`. DEL_MATCH (op 7) clears it at the lowest exact binary hit of the staged word. Each removal pulses `upd_strobe` with `upd_write`=0 and the freed index. A DEL_MATCH with no hit pulses nothing.
- R10: WR_FREE (op 4) stores at the lowest invalid index and strobes it. When the table is full it changes nothing and does not strobe.
- R11: `full` is high exactly when every valid flag is set.
- R12: Reset clears all valid flags. After reset `full`, `res_valid` and `upd_strobe` are low and `cmd_ready` is high.
- R13: WR_MATCH (op 5) with ternary key `cmd_data` overwrites the lowest hitting entry with the staged word and strobes that index. With no hit it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 4 | Operation code |
| cmd_data | input | 32 | Half word, ternary value or search key |
| cmd_mask | input | 32 | Ternary mask, 0 marks don't-care |
| cmd_index | input | IDX_W (5) | Entry index for indexed ops and reads |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_match | output | 1 | Search hit, or entry valid for reads |
| res_index | output | IDX_W (5) | Winning index, zero on a miss |
| res_data | output | 32 | Read data |
| upd_strobe | output | 1 | One-cycle pulse on every store or removal |
| upd_write | output | 1 | 1 for a store, 0 for a removal |
| upd_index | output | IDX_W (5) | Index stored or freed |
| full | output | 1 | All entries valid |

## Verification
The ternary search is tried with a /16 prefix and a /8 prefix that overlap. One key falls under both prefixes, one falls only under the /8 and one falls under neither. These three keys separate the priority order from the bit-pair match rule and from the miss encoding. A binary entry is searched with its exact word and with a word that differs in one high bit, which shows that both halves are compared. Random traffic then mixes ternary prefixes, raw binary words, removals and keys derived from stored entries, so that hits, multiple hits and misses all occur. Filling the table through the free-slot path, then freeing one slot, checks the full flag and the rule that a store to a full table is dropped.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [3:0] {
    OP_STAGE_LO   = 4'd0,
    OP_STAGE_HI   = 4'd1,
    OP_STAGE_TERN = 4'd2,
    OP_WR_IDX     = 4'd3,
    OP_WR_FREE    = 4'd4,
    OP_WR_MATCH   = 4'd5,
    OP_DEL_IDX    = 4'd6,
    OP_DEL_MATCH  = 4'd7,
    OP_SRCH_TERN  = 4'd8,
    OP_SRCH_BIN   = 4'd9,
    OP_RD_LO      = 4'd10,
    OP_RD_HI      = 4'd11
  } tcam_op_e;

  function automatic logic op_has_result(input logic [3:0] op);
    return (op == OP_SRCH_TERN) || (op == OP_SRCH_BIN) ||
           (op == OP_RD_LO) || (op == OP_RD_HI);
  endfunction
endpackage

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tcam_stage.sv
module tcam_stage #(
  parameter int KEY_W = 32,
  localparam int WORD_W = 2 * KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              ld_tern,
  input  logic [KEY_W-1:0]  value,
  input  logic [KEY_W-1:0]  mask,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (ld_tern) begin
      word[KEY_W-1:0]      <= value & mask;
      word[WORD_W-1:KEY_W] <= ~value & mask;
    end else begin
      if (ld_lo) word[KEY_W-1:0]      <= value;
      if (ld_hi) word[WORD_W-1:KEY_W] <= value;
    end
  end
endmodule

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int DEPTH = 32,
  parameter int KEY_W = 32,
  parameter int IDX_W = 5,
  localparam int WORD_W = 2 * KEY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [KEY_W-1:0]  key,
  input  logic [WORD_W-1:0] cmp,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DEPTH-1:0]  tern_hits,
  output logic [DEPTH-1:0]  bin_hits,
  output logic [DEPTH-1:0]  valid_vec,
  output logic [WORD_W-1:0] rd_word,
  output logic              rd_valid
);
  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic sel_wr, sel_clr;
    assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(g));
    assign sel_clr = clr_en && (clr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cells[g]     <= '0;
        valid_vec[g] <= 1'b0;
      end else if (sel_wr) begin
        cells[g]     <= wr_word;
        valid_vec[g] <= 1'b1;
      end else if (sel_clr) begin
        valid_vec[g] <= 1'b0;
      end
    end

    // a 1 in the low half demands key 1, a 1 in the high half demands key 0
    assign tern_hits[g] = valid_vec[g] &&
                          ((cells[g][KEY_W-1:0] & ~key) == '0) &&
                          ((cells[g][WORD_W-1:KEY_W] & key) == '0);
    assign bin_hits[g]  = valid_vec[g] && (cells[g] == cmp);
  end

  always_comb begin
    rd_word  = '0;
    rd_valid = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_word  = cells[i];
        rd_valid = valid_vec[i];
      end
    end
  end
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter int DEPTH = 32,
  parameter int KEY_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int WORD_W = 2 * KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [3:0]       cmd_op,
  input  logic [KEY_W-1:0] cmd_data,
  input  logic [KEY_W-1:0] cmd_mask,
  input  logic [IDX_W-1:0] cmd_index,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_match,
  output logic [IDX_W-1:0] res_index,
  output logic [KEY_W-1:0] res_data,
  output logic             upd_strobe,
  output logic             upd_write,
  output logic [IDX_W-1:0] upd_index,
  output logic             full
);
  import tcam_pkg::*;

  logic              fire;
  logic [WORD_W-1:0] staged;
  logic [DEPTH-1:0]  tern_hits, bin_hits, valid_vec;
  logic [WORD_W-1:0] rd_word;
  logic              rd_valid;
  logic              t_hit, b_hit, f_hit;
  logic [IDX_W-1:0]  t_idx, b_idx, f_idx;

  logic              wr_en, clr_en, res_load, res_m_nx;
  logic [IDX_W-1:0]  wr_idx, clr_idx, res_i_nx;
  logic [KEY_W-1:0]  res_d_nx;

  assign cmd_ready = !res_valid || res_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign full      = &valid_vec;

  tcam_stage #(.KEY_W(KEY_W)) i_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld_lo  (fire && cmd_op == OP_STAGE_LO),
    .ld_hi  (fire && cmd_op == OP_STAGE_HI),
    .ld_tern(fire && cmd_op == OP_STAGE_TERN),
    .value  (cmd_data),
    .mask   (cmd_mask),
    .word   (staged)
  );

  tcam_store #(.DEPTH(DEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_word  (staged),
    .clr_en   (clr_en),
    .clr_idx  (clr_idx),
    .key      (cmd_data),
    .cmp      (staged),
    .rd_idx   (cmd_index),
    .tern_hits(tern_hits),
    .bin_hits (bin_hits),
    .valid_vec(valid_vec),
    .rd_word  (rd_word),
    .rd_valid (rd_valid)
  );

  tcam_prio #(.N(DEPTH), .IW(IDX_W)) i_prio_tern (
    .req(tern_hits), .hit(t_hit), .idx(t_idx));
  tcam_prio #(.N(DEPTH), .IW(IDX_W)) i_prio_bin (
    .req(bin_hits), .hit(b_hit), .idx(b_idx));
  tcam_prio #(.N(DEPTH), .IW(IDX_W)) i_prio_free (
    .req(~valid_vec), .hit(f_hit), .idx(f_idx));

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = cmd_index;
    clr_en   = 1'b0;
    clr_idx  = cmd_index;
    res_load = 1'b0;
    res_m_nx = 1'b0;
    res_i_nx = '0;
    res_d_nx = '0;
    case (cmd_op)
      OP_WR_IDX:    wr_en = fire;
      OP_WR_FREE: begin
        wr_en  = fire && f_hit;
        wr_idx = f_idx;
      end
      OP_WR_MATCH: begin
        wr_en  = fire && t_hit;
        wr_idx = t_idx;
      end
      OP_DEL_IDX:   clr_en = fire;
      OP_DEL_MATCH: begin
        clr_en  = fire && b_hit;
        clr_idx = b_idx;
      end
      OP_SRCH_TERN: begin
        res_load = fire;
        res_m_nx = t_hit;
        res_i_nx = t_hit ? t_idx : '0;
      end
      OP_SRCH_BIN: begin
        res_load = fire;
        res_m_nx = b_hit;
        res_i_nx = b_hit ? b_idx : '0;
      end
      OP_RD_LO: begin
        res_load = fire;
        res_m_nx = rd_valid;
        res_i_nx = cmd_index;
        res_d_nx = rd_word[KEY_W-1:0];
      end
      OP_RD_HI: begin
        res_load = fire;
        res_m_nx = rd_valid;
        res_i_nx = cmd_index;
        res_d_nx = rd_word[WORD_W-1:KEY_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_match <= 1'b0;
      res_index <= '0;
      res_data  <= '0;
    end else if (res_load) begin
      res_valid <= 1'b1;
      res_match <= res_m_nx;
      res_index <= res_i_nx;
      res_data  <= res_d_nx;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_strobe <= 1'b0;
      upd_write  <= 1'b0;
      upd_index  <= '0;
    end else begin
      upd_strobe <= wr_en || clr_en;
      upd_write  <= wr_en;
      if (wr_en)       upd_index <= wr_idx;
      else if (clr_en) upd_index <= clr_idx;
    end
  end
endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
  parameter int DEPTH = 32,
  parameter int KEY_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [3:0]       cmd_op,
  input logic [IDX_W-1:0] cmd_index,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_match,
  input logic [IDX_W-1:0] res_index,
  input logic [KEY_W-1:0] res_data,
  input logic             upd_strobe,
  input logic             upd_write,
  input logic [IDX_W-1:0] upd_index,
  input logic             full
);
  import tcam_pkg::*;

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  AST_HELD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !cmd_ready); // R7
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_match) &&
                                   $stable(res_index) && $stable(res_data))); // R7
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op_has_result(cmd_op)) |=> res_valid); // R6
  AST_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !op_has_result(cmd_op)) |=> !res_valid); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == OP_SRCH_TERN || cmd_op == OP_SRCH_BIN))
      |=> (res_match || res_index == '0)); // R5
  AST_DEL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_DEL_IDX)
      |=> (upd_strobe && !upd_write && upd_index == $past(cmd_index))); // R9
  AST_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_WR_IDX)
      |=> (upd_strobe && upd_write && upd_index == $past(cmd_index))); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_WR_FREE && full) |=> (!upd_strobe && full)); // R10
  AST_QUIET_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op >= 4'd12) |=> (!upd_strobe && $stable(full))); // R6
endmodule

bind tcam_lookup tcam_lookup_chk #(.DEPTH(DEPTH), .KEY_W(KEY_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_index(cmd_index), .res_valid(res_valid),
  .res_ready(res_ready), .res_match(res_match), .res_index(res_index),
  .res_data(res_data), .upd_strobe(upd_strobe), .upd_write(upd_write),
  .upd_index(upd_index), .full(full)
);

// File: tb/test_tcam_lookup.sv
module test_tcam_lookup;
  localparam int D = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic [31:0] cmd_mask = '0;
  logic [4:0]  cmd_index = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_match;
  logic [4:0]  res_index;
  logic [31:0] res_data;
  logic        upd_strobe, upd_write;
  logic [4:0]  upd_index;
  logic        full;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [63:0] m_word [D];
  bit          m_val  [D];
  logic [63:0] m_stage;

  always #10 clk = ~clk;

  tcam_lookup i_tcam_lookup (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .cmd_index(cmd_index), .res_valid(res_valid), .res_ready(res_ready),
    .res_match(res_match), .res_index(res_index), .res_data(res_data),
    .upd_strobe(upd_strobe), .upd_write(upd_write), .upd_index(upd_index),
    .full(full)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit t_hit(int j, logic [31:0] k);
    return m_val[j] && ((m_word[j][31:0] & ~k) == 0) && ((m_word[j][63:32] & k) == 0);
  endfunction

  function automatic int t_first(logic [31:0] k);
    for (int j = 0; j < D; j++) if (t_hit(j, k)) return j;
    return -1;
  endfunction

  function automatic int b_first(logic [63:0] w);
    for (int j = 0; j < D; j++) if (m_val[j] && m_word[j] == w) return j;
    return -1;
  endfunction

  function automatic int free_first();
    for (int j = 0; j < D; j++) if (!m_val[j]) return j;
    return -1;
  endfunction

  function automatic bit m_full();
    for (int j = 0; j < D; j++) if (!m_val[j]) return 0;
    return 1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    res_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int j = 0; j < D; j++) begin m_val[j] = 0; m_word[j] = '0; end
    m_stage = '0;
  endtask

  task automatic run(input string req, input logic [3:0] op, input logic [31:0] d,
                     input logic [31:0] m, input logic [4:0] ix);
    bit e_rv = 0, e_m = 0, e_u = 0, e_w = 0;
    logic [4:0] e_i = '0, e_ui = '0;
    logic [31:0] e_d = '0;
    int h;
    case (op)
      4'd3: begin e_u = 1; e_w = 1; e_ui = ix; end
      4'd4: begin h = free_first(); if (h >= 0) begin e_u = 1; e_w = 1; e_ui = 5'(h); end end
      4'd5: begin h = t_first(d); if (h >= 0) begin e_u = 1; e_w = 1; e_ui = 5'(h); end end
      4'd6: begin e_u = 1; e_ui = ix; end
      4'd7: begin h = b_first(m_stage); if (h >= 0) begin e_u = 1; e_ui = 5'(h); end end
      4'd8: begin e_rv = 1; h = t_first(d); e_m = (h >= 0); e_i = (h >= 0) ? 5'(h) : '0; end
      4'd9: begin e_rv = 1; h = b_first(m_stage); e_m = (h >= 0); e_i = (h >= 0) ? 5'(h) : '0; end
      4'd10: begin e_rv = 1; e_m = m_val[ix]; e_i = ix; e_d = m_word[ix][31:0]; end
      4'd11: begin e_rv = 1; e_m = m_val[ix]; e_i = ix; e_d = m_word[ix][63:32]; end
      default: ;
    endcase
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_mask = m; cmd_index = ix; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({req, " res_valid"}, 64'(res_valid), 64'(e_rv));
    if (e_rv) begin
      chk({req, " res_match"}, 64'(res_match), 64'(e_m));
      chk({req, " res_index"}, 64'(res_index), 64'(e_i));
      if (op >= 4'd10) chk({req, " res_data"}, 64'(res_data), 64'(e_d));
    end
    chk({req, " upd_strobe"}, 64'(upd_strobe), 64'(e_u));
    if (e_u) begin
      chk({req, " upd_write"}, 64'(upd_write), 64'(e_w));
      chk({req, " upd_index"}, 64'(upd_index), 64'(e_ui));
    end
    case (op)
      4'd0: m_stage[31:0] = d;
      4'd1: m_stage[63:32] = d;
      4'd2: m_stage = {~d & m, d & m};
      default: if (e_u) begin
        m_val[e_ui] = e_w;
        if (e_w) m_word[e_ui] = m_stage;
      end
    endcase
    chk("R11 full", 64'(full), 64'(m_full()));
  endtask

  task automatic put_tern(input logic [31:0] a, input logic [31:0] m, input logic [4:0] ix);
    run("R1 stage", 4'd2, a, m, '0);
    run("R8 write", 4'd3, '0, '0, ix);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    @(negedge clk);
    chk("R12 full", 64'(full), 64'd0);
    chk("R12 res_valid", 64'(res_valid), 64'd0);
    chk("R12 upd_strobe", 64'(upd_strobe), 64'd0);
    chk("R12 cmd_ready", 64'(cmd_ready), 64'd1);
    run("R5 empty search", 4'd8, 32'hC0A80101, '0, '0);

    // overlapping /16 and /8 prefixes
    put_tern(32'hC0A80000, 32'hFFFF0000, 5'd5);
    run("R1 read lo", 4'd10, '0, '0, 5'd5);
    run("R1 read hi", 4'd11, '0, '0, 5'd5);
    put_tern(32'hC0000000, 32'hFF000000, 5'd9);
    run("R3 both prefixes", 4'd8, 32'hC0A80101, '0, '0);
    run("R2 short prefix", 4'd8, 32'hC0110000, '0, '0);
    run("R5 no prefix", 4'd8, 32'h0A000000, '0, '0);

    // binary exact match
    run("R1 stage lo", 4'd0, 32'h12345678, '0, '0);
    run("R1 stage hi", 4'd1, 32'h9ABCDEF0, '0, '0);
    run("R8 write bin", 4'd3, '0, '0, 5'd2);
    run("R4 exact", 4'd9, '0, '0, '0);
    run("R1 stage hi", 4'd1, 32'h1ABCDEF0, '0, '0);
    run("R4 one bit off", 4'd9, '0, '0, '0);
    run("R1 stage hi", 4'd1, 32'h9ABCDEF0, '0, '0);
    run("R9 del match", 4'd7, '0, '0, '0);
    run("R9 del miss", 4'd7, '0, '0, '0);
    run("R4 after delete", 4'd9, '0, '0, '0);
    run("R9 del idx", 4'd6, '0, '0, 5'd5);
    run("R3 after del", 4'd8, 32'hC0A80101, '0, '0);
    run("R6 quiet op", 4'd13, 32'hFFFFFFFF, '0, 5'd9);
    run("R6 quiet check", 4'd8, 32'hC0110000, '0, '0);

    // associative overwrite
    run("R1 stage", 4'd2, 32'hC1000000, 32'hFF000000, '0);
    run("R13 wr match", 4'd5, 32'hC0123456, '0, '0);
    run("R13 new value", 4'd8, 32'hC1000001, '0, '0);
    run("R13 wr miss", 4'd5, 32'h0F000000, '0, '0);

    // fill through free slots
    for (int j = 0; j < D; j++) run("R10 free", 4'd4, '0, '0, '0);
    chk("R11 full set", 64'(full), 64'd1);
    run("R10 full drop", 4'd4, '0, '0, '0);
    run("R9 del idx", 4'd6, '0, '0, 5'd3);
    run("R10 refill", 4'd4, '0, '0, '0);

    // back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    cmd_op = 4'd10; cmd_index = 5'd7; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 4'd8; cmd_data = 32'h0;
    chk("R7 res_valid", 64'(res_valid), 64'd1);
    chk("R7 cmd_ready", 64'(cmd_ready), 64'd0);
    chk("R7 index", 64'(res_index), 64'd7);
    @(negedge clk);
    chk("R7 held", 64'(res_valid), 64'd1);
    chk("R7 held index", 64'(res_index), 64'd7);
    res_ready = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 next result", 64'(res_valid), 64'd1);
    chk("R7 next index", 64'(res_index), 64'(t_first(32'h0) >= 0 ? t_first(32'h0) : 0));
    @(negedge clk);

    // random mix
    do_reset();
    for (int it = 0; it < 400; it++) begin
      int sel = $urandom_range(0, 9);
      logic [4:0] ix = 5'($urandom_range(0, D - 1));
      if (sel <= 2) begin
        int len = $urandom_range(0, 32);
        logic [31:0] msk = (len == 0) ? 32'h0 : ~((32'h1 << (32 - len)) - 1);
        put_tern($urandom, msk, ix);
      end else if (sel == 3) begin
        run("R1 stage lo", 4'd0, $urandom, '0, '0);
        run("R1 stage hi", 4'd1, $urandom, '0, '0);
        run("R8 write", 4'd3, '0, '0, ix);
      end else if (sel == 4) begin
        run("R9 del idx", 4'd6, '0, '0, ix);
      end else if (sel == 5) begin
        run("R4 bin search", 4'd9, '0, '0, '0);
      end else begin
        logic [31:0] k = $urandom;
        if (m_val[ix]) k = m_word[ix][31:0] | (k & ~(m_word[ix][31:0] | m_word[ix][63:32]));
        run("R2 R3 tern search", 4'd8, k, '0, '0);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule